// File: doc/BRIEF.md
# 32-bit Integer Execute Unit

This block is the combinational execute stage of a 32-bit register machine. It receives an already decoded operation code, the values of two register operands and a 16-bit immediate field, and returns the 32-bit value to write back together with a write-enable. Operand `src_a` is the value of the first named register. Operand `src_b` is the value of the second register, which two-operand forms also overwrite. The result settles in the same cycle as the inputs. No clock or state is involved.

The operation set covers the following:

- addition, subtraction and reverse subtraction;
- an unsigned 16x16 multiply on the low halfwords;
- an unsigned divide by a halfword;
- bitwise AND, OR, XOR and NOT;
- left, logical right and arithmetic right shifts;
- moves, including the high-half add used to build 32-bit constants.

Each immediate form uses a fixed extension. The short 5-bit field is sign-extended. The 16-bit field is sign-extended for arithmetic forms and zero-extended for logical forms.

Two status outputs report problems. An operation code outside the defined set drops the write-enable and raises `illegal_op`. A divide with a zero divisor returns the old destination value and raises `div_zero`.

Top module: `int_exec_unit`

## Requirements
- R1: Codes 26 to 31 are illegal: `result` is 0, `wr_en` is 0 and `illegal_op` is 1. Codes 0 to 25 give `wr_en` 1 and `illegal_op` 0.
- R2: Code 0 yields `src_b + src_a`. Code 1 yields `src_b` plus imm[4:0] sign-extended from bit 4. Code 2 yields `src_a` plus imm sign-extended from bit 15. All sums wrap modulo 2^32.
- R3: Code 3 yields `src_b - src_a`. Code 4 yields `src_a - src_b`.
- R4: Code 5 yields the unsigned product `src_b[15:0]*src_a[15:0]`. Code 6 yields the low 32 bits of `src_b[15:0]` times the sign-extended imm[4:0]. Code 7 yields `src_a[15:0]*imm`, with imm zero-extended.
- R5: Code 8 yields the unsigned quotient `src_b / src_a[15:0]`; bits 31:16 of `src_a` are ignored.
- R6: Code 8 with `src_a[15:0]` equal to 0 yields `src_b` and raises `div_zero`. `div_zero` is 0 in every other case.
- R7: Codes 9, 11 and 13 yield `src_b` AND, OR and XOR `src_a` respectively. Code 15 yields `~src_a`.
- R8: Codes 10, 12 and 14 yield `src_a` AND, OR and XOR the zero-extended imm respectively.
- R9: Code 16 shifts `src_b` left by imm[4:0], and code 17 shifts it left by `src_a[4:0]`. Vacated bits are zero and higher amount bits are ignored.
- R10: Codes 18 (amount imm[4:0]) and 19 (amount `src_a[4:0]`) shift `src_b` right, filling with zeros.
- R11: Codes 20 (amount imm[4:0]) and 21 (amount `src_a[4:0]`) shift `src_b` right, filling with copies of bit 31.
- R12: Code 22 yields `src_a`. Code 23 yields imm[4:0] sign-extended. Code 24 yields `src_a` plus imm sign-extended from bit 15.
- R13: Code 25 yields `src_a + (imm << 16)`, with the low half of the added term zero and the sum wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Decoded operation code (0 to 25 valid) |
| src_a | input | 32 | First register operand value |
| src_b | input | 32 | Second register operand, old destination value |
| imm | input | 16 | Immediate field; low 5 bits form the short immediate |
| result | output | 32 | Write-back value |
| wr_en | output | 1 | Result should be written back |
| illegal_op | output | 1 | Operation code is undefined |
| div_zero | output | 1 | Divide attempted with a zero halfword divisor |

## Verification
The checker watches every settled input combination and enforces five properties:

- the write-enable and the illegal flag are always complementary;
- an illegal code forces a zero result;
- `div_zero` appears only for a divide with a zero low halfword, and then passes the destination value through;
- reverse subtraction stays consistent with its operands;
- logical-immediate and high-half results keep the halves the operation must not disturb.

Only the bench's vectors show the exact arithmetic values. These cover sign versus zero extension of each immediate, multiply truncation, the quotient, and the fill bits and amount masking of each shift.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned SIMM_W  = 5;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);
  localparam int unsigned OP_W    = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,  OP_ADD_S5 = 5'd1,  OP_ADD_I  = 5'd2,
    OP_SUB    = 5'd3,  OP_RSUB   = 5'd4,
    OP_MUL    = 5'd5,  OP_MUL_S5 = 5'd6,  OP_MUL_I  = 5'd7,
    OP_DIV    = 5'd8,
    OP_AND    = 5'd9,  OP_AND_I  = 5'd10, OP_OR     = 5'd11,
    OP_OR_I   = 5'd12, OP_XOR    = 5'd13, OP_XOR_I  = 5'd14,
    OP_NOT    = 5'd15,
    OP_SLL_I  = 5'd16, OP_SLL_R  = 5'd17, OP_SRL_I  = 5'd18,
    OP_SRL_R  = 5'd19, OP_SRA_I  = 5'd20, OP_SRA_R  = 5'd21,
    OP_MOV    = 5'd22, OP_MOV_S5 = 5'd23, OP_MOV_A  = 5'd24,
    OP_MOV_HI = 5'd25
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_MOV_HI;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_LOGIC = 2'd1,
    SH_ARITH = 2'd2
  } shift_mode_e;
endpackage

// File: rtl/exec_imm_ext.sv
module exec_imm_ext #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned SIMM_W = 5
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] short_sext,
  output logic [DATA_W-1:0] long_sext,
  output logic [DATA_W-1:0] long_zext,
  output logic [DATA_W-1:0] long_high
);
  localparam int unsigned SPAD = DATA_W - SIMM_W;
  localparam int unsigned LPAD = DATA_W - IMM_W;

  // Replicate the top bit of each field to widen it
  assign short_sext = {{SPAD{imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
  assign long_sext  = {{LPAD{imm[IMM_W-1]}}, imm};
  assign long_zext  = {{LPAD{1'b0}}, imm};
  // Immediate placed in the upper half, lower half cleared
  assign long_high  = {imm, {LPAD{1'b0}}};
endmodule

// File: rtl/exec_shifter.sv
module exec_shifter
  import exec_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amount,
  input  shift_mode_e        mode,
  output logic [DATA_W-1:0]  dout
);
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic              fill;

  assign fill     = (mode == SH_ARITH) ? din[DATA_W-1] : 1'b0;
  assign stage[0] = din;

  // One log stage per amount bit, each moving by a power of two
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    always_comb begin
      if (!amount[k])
        stage[k+1] = stage[k];
      else if (mode == SH_LEFT)
        stage[k+1] = {stage[k][DATA_W-1-DIST:0], {DIST{1'b0}}};
      else
        stage[k+1] = {{DIST{fill}}, stage[k][DATA_W-1:DIST]};
    end
  end

  assign dout = stage[SHAMT_W];
endmodule

// File: rtl/exec_muldiv.sv
module exec_muldiv #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] short_sext,
  input  logic [DATA_W-1:0] long_zext,
  output logic [DATA_W-1:0] prod_rr,
  output logic [DATA_W-1:0] prod_short,
  output logic [DATA_W-1:0] prod_imm,
  output logic [DATA_W-1:0] quotient,
  output logic              divisor_zero
);
  localparam int unsigned PAD = DATA_W - HALF_W;

  logic [DATA_W-1:0] a_lo, b_lo, divisor, safe_div;

  // Only the low halfwords take part, zero-extended
  assign a_lo = {{PAD{1'b0}}, src_a[HALF_W-1:0]};
  assign b_lo = {{PAD{1'b0}}, src_b[HALF_W-1:0]};

  assign prod_rr    = b_lo * a_lo;
  assign prod_short = b_lo * short_sext;
  assign prod_imm   = a_lo * long_zext;

  assign divisor      = a_lo;
  assign divisor_zero = (divisor == '0);
  assign safe_div     = divisor_zero ? {{(DATA_W-1){1'b0}}, 1'b1} : divisor;
  // A zero divisor passes the dividend through unchanged
  assign quotient     = divisor_zero ? src_b : (src_b / safe_div);
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
(
  input  logic [4:0]  op_sel,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [15:0] imm,
  output logic [31:0] result,
  output logic        wr_en,
  output logic        illegal_op,
  output logic        div_zero
);
  logic [DATA_W-1:0]  short_sext, long_sext, long_zext, long_high;
  logic [DATA_W-1:0]  prod_rr, prod_short, prod_imm, quotient;
  logic               divisor_zero;
  logic [DATA_W-1:0]  add_x, add_y, sum;
  logic               add_sub;
  logic [SHAMT_W-1:0] sh_amt;
  shift_mode_e        sh_mode;
  logic [DATA_W-1:0]  sh_out;
  op_e                op;
  logic               legal;

  assign legal = (op_sel <= OP_LAST);
  assign op    = op_e'(op_sel);

  exec_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) u_imm (
    .imm(imm), .short_sext(short_sext), .long_sext(long_sext),
    .long_zext(long_zext), .long_high(long_high)
  );

  exec_muldiv #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_muldiv (
    .src_a(src_a), .src_b(src_b), .short_sext(short_sext),
    .long_zext(long_zext), .prod_rr(prod_rr), .prod_short(prod_short),
    .prod_imm(prod_imm), .quotient(quotient), .divisor_zero(divisor_zero)
  );

  exec_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .din(src_b), .amount(sh_amt), .mode(sh_mode), .dout(sh_out)
  );

  // Operand steering for the single shared adder
  always_comb begin
    add_x   = src_b;
    add_y   = src_a;
    add_sub = 1'b0;
    case (op)
      OP_ADD_S5: add_y = short_sext;
      OP_ADD_I,
      OP_MOV_A:  begin add_x = src_a; add_y = long_sext; end
      OP_MOV_HI: begin add_x = src_a; add_y = long_high; end
      OP_SUB:    add_sub = 1'b1;
      OP_RSUB:   begin add_x = src_a; add_y = src_b; add_sub = 1'b1; end
      default:   ;
    endcase
  end

  assign sum = add_x + (add_sub ? ~add_y : add_y) + {{(DATA_W-1){1'b0}}, add_sub};

  // Shift amount source and fill mode
  always_comb begin
    sh_amt  = imm[SHAMT_W-1:0];
    sh_mode = SH_LEFT;
    case (op)
      OP_SLL_R: sh_amt = src_a[SHAMT_W-1:0];
      OP_SRL_I: sh_mode = SH_LOGIC;
      OP_SRL_R: begin sh_mode = SH_LOGIC; sh_amt = src_a[SHAMT_W-1:0]; end
      OP_SRA_I: sh_mode = SH_ARITH;
      OP_SRA_R: begin sh_mode = SH_ARITH; sh_amt = src_a[SHAMT_W-1:0]; end
      default:  ;
    endcase
  end

  // Result selection
  always_comb begin
    result = '0;
    if (legal) begin
      case (op)
        OP_ADD, OP_ADD_S5, OP_ADD_I, OP_SUB, OP_RSUB,
        OP_MOV_A, OP_MOV_HI:                  result = sum;
        OP_MUL:                               result = prod_rr;
        OP_MUL_S5:                            result = prod_short;
        OP_MUL_I:                             result = prod_imm;
        OP_DIV:                               result = quotient;
        OP_AND:                               result = src_b & src_a;
        OP_OR:                                result = src_b | src_a;
        OP_XOR:                               result = src_b ^ src_a;
        OP_AND_I:                             result = src_a & long_zext;
        OP_OR_I:                              result = src_a | long_zext;
        OP_XOR_I:                             result = src_a ^ long_zext;
        OP_NOT:                               result = ~src_a;
        OP_SLL_I, OP_SLL_R, OP_SRL_I,
        OP_SRL_R, OP_SRA_I, OP_SRA_R:         result = sh_out;
        OP_MOV:                               result = src_a;
        OP_MOV_S5:                            result = short_sext;
        default:                              result = '0;
      endcase
    end
  end

  assign wr_en      = legal;
  assign illegal_op = ~legal;
  assign div_zero   = legal && (op == OP_DIV) && divisor_zero;
endmodule

// File: rtl/int_exec_unit_checker.sv
module int_exec_unit_checker (
  input logic [4:0]  op_sel,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [15:0] imm,
  input logic [31:0] result,
  input logic        wr_en,
  input logic        illegal_op,
  input logic        div_zero
);
  logic known;
  assign known = !$isunknown({op_sel, src_a, src_b, imm});

  always_comb begin
    if (known) begin
      p_wr_vs_illegal_r1: assert (wr_en != illegal_op)
        else $error("write-enable and illegal flag not complementary");
      if (illegal_op) begin
        p_illegal_zero_r1: assert (result == 32'h0 && op_sel >= 5'd26)
          else $error("illegal code produced a value");
      end
      if (div_zero) begin
        p_divz_pass_r6: assert (op_sel == 5'd8 && src_a[15:0] == 16'h0 && result == src_b)
          else $error("divide-by-zero flag inconsistent");
      end
      if (op_sel == 5'd4) begin
        p_rsub_consistent_r3: assert (result + src_b == src_a)
          else $error("reverse subtract wrong");
      end
      if (op_sel == 5'd10) begin
        p_andi_upper_clear_r8: assert (result[31:16] == 16'h0)
          else $error("AND with zero-extended immediate left upper bits");
      end
      if (op_sel == 5'd25) begin
        p_movhi_low_kept_r13: assert (result[15:0] == src_a[15:0])
          else $error("high-half add disturbed low half");
      end
    end
  end
endmodule

bind int_exec_unit int_exec_unit_checker u_checker (
  .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
  .result(result), .wr_en(wr_en), .illegal_op(illegal_op), .div_zero(div_zero)
);

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [4:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm;
  logic [31:0] result;
  logic        wr_en, illegal_op, div_zero;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  int_exec_unit u_int_exec_unit (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
    .result(result), .wr_en(wr_en), .illegal_op(illegal_op), .div_zero(div_zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  5'd0,  32'h00000005, 32'h00000007, 16'h0000, 32'h0000000C}, // R2 add
    '{8'd2,  5'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000}, // R2 wrap
    '{8'd2,  5'd1,  32'h00000000, 32'h00000010, 16'h001F, 32'h0000000F}, // R2 short -1
    '{8'd2,  5'd1,  32'h00000000, 32'h00000010, 16'hFFF0, 32'h00000000}, // R2 upper imm ignored
    '{8'd2,  5'd2,  32'h00000100, 32'h00000000, 16'h8000, 32'hFFFF8100}, // R2 sext16
    '{8'd3,  5'd3,  32'h00000003, 32'h0000000A, 16'h0000, 32'h00000007}, // R3 sub
    '{8'd3,  5'd4,  32'h00000003, 32'h0000000A, 16'h0000, 32'hFFFFFFF9}, // R3 rsub
    '{8'd4,  5'd5,  32'h1234FFFF, 32'hABCD0002, 16'h0000, 32'h0001FFFE}, // R4 low halves
    '{8'd4,  5'd6,  32'h00000000, 32'h00000003, 16'h001E, 32'hFFFFFFFA}, // R4 times -2
    '{8'd4,  5'd7,  32'h0001FFFF, 32'h00000000, 16'hFFFF, 32'hFFFE0001}, // R4 zext imm
    '{8'd5,  5'd8,  32'hFFFF0007, 32'h00000064, 16'h0000, 32'h0000000E}, // R5 100/7
    '{8'd7,  5'd9,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hF000F000}, // R7 and
    '{8'd7,  5'd11, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hFFF0FFF0}, // R7 or
    '{8'd7,  5'd13, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'h0FF00FF0}, // R7 xor
    '{8'd7,  5'd15, 32'h0000FFFF, 32'h12345678, 16'h0000, 32'hFFFF0000}, // R7 not
    '{8'd8,  5'd10, 32'hFFFFFFFF, 32'h00000000, 16'h8001, 32'h00008001}, // R8 andi
    '{8'd8,  5'd12, 32'h12340000, 32'h00000000, 16'h8000, 32'h12348000}, // R8 ori
    '{8'd8,  5'd14, 32'hFFFFFFFF, 32'h00000000, 16'h00FF, 32'hFFFFFF00}, // R8 xori
    '{8'd9,  5'd16, 32'h00000000, 32'h00000001, 16'h0024, 32'h00000010}, // R9 mask amount
    '{8'd9,  5'd17, 32'hFFFFFFFF, 32'h00000003, 16'h0000, 32'h80000000}, // R9 by 31
    '{8'd10, 5'd18, 32'h00000000, 32'h80000000, 16'h0004, 32'h08000000}, // R10 imm
    '{8'd10, 5'd19, 32'h00000021, 32'h80000000, 16'h0000, 32'h40000000}, // R10 reg masked
    '{8'd11, 5'd20, 32'h00000000, 32'h80000000, 16'h0004, 32'hF8000000}, // R11 sign fill
    '{8'd11, 5'd21, 32'h0000003E, 32'h40000000, 16'h0000, 32'h00000001}, // R11 positive
    '{8'd12, 5'd22, 32'hDEADBEEF, 32'h00000000, 16'h0000, 32'hDEADBEEF}, // R12 mov
    '{8'd12, 5'd23, 32'h00000000, 32'h00000000, 16'h0010, 32'hFFFFFFF0}, // R12 short sext
    '{8'd12, 5'd24, 32'h00000010, 32'h00000000, 16'hFFF0, 32'h00000000}, // R12 movea
    '{8'd13, 5'd25, 32'h00001234, 32'h00000000, 16'hABCD, 32'hABCD1234}, // R13 build const
    '{8'd13, 5'd25, 32'hFFFF0001, 32'h00000000, 16'h0001, 32'h00000001}  // R13 wrap
  };

  task automatic apply(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i);
    @(posedge clk);
    op_sel = o; src_a = a; src_b = b; imm = i;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op_sel, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_sel = '0; src_a = '0; src_b = '0; imm = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Idle state: add of zeros gives zero with write enabled (R1, R2)
    check("R1", {result, wr_en, illegal_op, div_zero}, {32'h0, 1'b1, 1'b0, 1'b0});

    for (int n = 0; n < NV; n++) begin
      apply(VECS[n].op, VECS[n].a, VECS[n].b, VECS[n].im);
      check($sformatf("R%0d", VECS[n].req), {result, wr_en, illegal_op, div_zero},
            {VECS[n].exp, 1'b1, 1'b0, 1'b0});
    end

    // R6: zero low halfword divisor passes destination through
    apply(5'd8, 32'h00010000, 32'h00000055, 16'h0);
    check("R6", {result, wr_en, illegal_op, div_zero}, {32'h00000055, 1'b1, 1'b0, 1'b1});
    // R6: nonzero divisor clears the flag, R5 quotient by 1
    apply(5'd8, 32'h00000001, 32'h00000055, 16'h0);
    check("R6", {result, wr_en, illegal_op, div_zero}, {32'h00000055, 1'b1, 1'b0, 1'b0});
    // R6: zero operand on a non-divide leaves flag low
    apply(5'd5, 32'h00000000, 32'h00000009, 16'h0);
    check("R6", {result, wr_en, illegal_op, div_zero}, {32'h0, 1'b1, 1'b0, 1'b0});

    // R1: every undefined code
    for (int c = 26; c < 32; c++) begin
      apply(5'(c), 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF);
      check("R1", {result, wr_en, illegal_op, div_zero}, {32'h0, 1'b0, 1'b1, 1'b0});
    end
    // R1: last legal code still writes
    apply(5'd25, 32'h0, 32'h0, 16'h0);
    check("R1", {result, wr_en, illegal_op, div_zero}, {32'h0, 1'b1, 1'b0, 1'b0});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule